// File: doc/BRIEF.md
# Jump-Avoiding Candidate State Sequencer

This block sits beside the cost evaluator of a predictive current controller for an asymmetric three-phase inverter. Two legs (A and C) have three levels and the middle leg (B) has two. The block keeps the switching-state index that is applied now, one of 18 states. When it is started, it lists the states the evaluator may test for the next period, one per clock, in ascending index order. It sets a last marker on the final one.

The permitted set leaves out every state that would move leg A or leg C directly between its lowest and highest level. When both three-level legs sit at their middle level, no state is removed for that reason. In that case the set keeps only the states whose leg B matches the applied state. No set ever holds more than 12 states, so the evaluator's loop is shorter than a full 18-state search.

The controller reports its choice through the apply strobe, which loads the stored index. The block has two named states:
- `SEQ_IDLE` waits for a start.
- `SEQ_EMIT` walks a captured copy of the permitted mask.

It has two transitions:
- Idle to emit, taken on start.
- Emit to idle, taken on the cycle that carries the last marker.

Top module: `cand_seq_top`

## Requirements
- R1: After reset the applied index is 0, and `cand_valid`, `cand_last` and `busy` are low.
- R2: An apply strobe with `apply_idx` below 18 loads that index, and it is visible on the next cycle. An apply strobe with an index of 18 or more leaves the stored index unchanged. Without a strobe the index holds.
- R3: A start seen in `SEQ_IDLE` moves to `SEQ_EMIT`. The first candidate is valid in the next cycle, followed by one candidate per clock, and `busy` is high while emitting.
- R4: Each permitted index is emitted exactly once, in strictly ascending order. `cand_last` marks the final one, and `cand_valid` is low in the cycle after it.
- R5: Legs are encoded as levels A,B,C per index: 0:000, 1:200, 2:220, 3:020, 4:022, 5:002, 6:202, 7:222, 8:120, 9:021, 10:102, 11:201, 12:100, 13:221, 14:121, 15:122, 16:001, 17:101. A candidate whose leg A or leg C level differs from the applied one by two is never emitted. For example, from 12 the set is {0,1,2,3,8,9,11,12,13,14,16,17}.
- R6: When the applied state has A=1 and C=1, only states with the same leg B level are emitted. From 14 this gives {2,3,4,7,8,9,13,14,15}, and from 17 it gives {0,1,5,6,10,11,12,16,17}.
- R7: Every sequence contains the applied index itself and has at most 12 entries.
- R8: A start raised while `busy` is high is ignored: the running sequence is neither restarted nor lengthened.
- R9: An apply during a sequence does not change the candidates of that sequence. The next sequence uses the new index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a candidate sequence (accepted only when idle) |
| apply | input | 1 | Load `apply_idx` as the applied state |
| apply_idx | input | 5 | Chosen state index |
| cand_valid | output | 1 | A candidate is on `cand_idx` |
| cand_idx | output | 5 | Candidate state index |
| cand_last | output | 1 | Final candidate of the sequence |
| busy | output | 1 | Sequence in progress |
| applied_idx | output | 5 | Currently applied state index |

## Verification
The assertions check four rules on every cycle:
- No emitted candidate is a full-bus step on leg A or C from the captured applied state.
- Consecutive candidates rise strictly.
- A last marker is followed by an idle cycle, and no sequence exceeds 12 entries.
- The applied index moves only on an in-range apply.

The assertions cannot show that the set is complete, that the leg-B filter applies exactly when both three-level legs sit mid-level, or that a start or apply during a sequence has no effect. The bench shows these by sweeping all 18 applied states and comparing each emitted set with one it computes from the leg levels.

// File: rtl/cand_seq_pkg.sv
package cand_seq_pkg;

    localparam int NUM_STATES = 18;
    localparam int IDX_W      = $clog2(NUM_STATES);
    localparam int MAX_CAND   = 12;

    typedef logic [1:0] lvl_t;

    typedef struct packed {
        lvl_t a;
        lvl_t b;
        lvl_t c;
    } legs_t;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_EMIT = 1'b1
    } seq_state_e;

    // Leg levels of each state index; numbering is part of the controller interface.
    function automatic legs_t legs_of(input logic [IDX_W-1:0] idx);
        legs_t l;
        unique case (idx)
            5'd0:    l = '{a: 2'd0, b: 2'd0, c: 2'd0};
            5'd1:    l = '{a: 2'd2, b: 2'd0, c: 2'd0};
            5'd2:    l = '{a: 2'd2, b: 2'd2, c: 2'd0};
            5'd3:    l = '{a: 2'd0, b: 2'd2, c: 2'd0};
            5'd4:    l = '{a: 2'd0, b: 2'd2, c: 2'd2};
            5'd5:    l = '{a: 2'd0, b: 2'd0, c: 2'd2};
            5'd6:    l = '{a: 2'd2, b: 2'd0, c: 2'd2};
            5'd7:    l = '{a: 2'd2, b: 2'd2, c: 2'd2};
            5'd8:    l = '{a: 2'd1, b: 2'd2, c: 2'd0};
            5'd9:    l = '{a: 2'd0, b: 2'd2, c: 2'd1};
            5'd10:   l = '{a: 2'd1, b: 2'd0, c: 2'd2};
            5'd11:   l = '{a: 2'd2, b: 2'd0, c: 2'd1};
            5'd12:   l = '{a: 2'd1, b: 2'd0, c: 2'd0};
            5'd13:   l = '{a: 2'd2, b: 2'd2, c: 2'd1};
            5'd14:   l = '{a: 2'd1, b: 2'd2, c: 2'd1};
            5'd15:   l = '{a: 2'd1, b: 2'd2, c: 2'd2};
            5'd16:   l = '{a: 2'd0, b: 2'd0, c: 2'd1};
            5'd17:   l = '{a: 2'd1, b: 2'd0, c: 2'd1};
            default: l = '{a: 2'd0, b: 2'd0, c: 2'd0};
        endcase
        return l;
    endfunction

    // True when two levels sit at opposite rails of a three-level leg.
    function automatic logic full_step(input lvl_t x, input lvl_t y);
        return ((x == 2'd0) && (y == 2'd2)) || ((x == 2'd2) && (y == 2'd0));
    endfunction

endpackage

// File: rtl/cand_mask_gen.sv
module cand_mask_gen
    import cand_seq_pkg::*;
#(
    parameter int N = NUM_STATES,
    parameter int W = IDX_W
) (
    input  logic [W-1:0] base_i,
    output logic [N-1:0] mask_o
);

    legs_t base_l;
    logic  mid_mid;

    assign base_l  = legs_of(base_i);
    assign mid_mid = (base_l.a == 2'd1) && (base_l.c == 2'd1);

    for (genvar g = 0; g < N; g++) begin : g_cand
        legs_t cl;
        logic  ac_ok;
        logic  b_ok;
        assign cl     = legs_of(W'(g));
        assign ac_ok  = !full_step(base_l.a, cl.a) && !full_step(base_l.c, cl.c);
        assign b_ok   = !mid_mid || (cl.b == base_l.b);
        assign mask_o[g] = ac_ok && b_ok;
    end

endmodule

// File: rtl/cand_pick_low.sv
module cand_pick_low
    import cand_seq_pkg::*;
#(
    parameter int N = NUM_STATES,
    parameter int W = IDX_W
) (
    input  logic [N-1:0] mask_i,
    output logic [W-1:0] idx_o,
    output logic         single_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                idx_o = W'(i);
            end
        end
    end

    assign single_o = ((mask_i & (mask_i - N'(1))) == '0);

endmodule

// File: rtl/cand_seq_fsm.sv
module cand_seq_fsm
    import cand_seq_pkg::*;
#(
    parameter int N = NUM_STATES,
    parameter int W = IDX_W,
    parameter int M = MAX_CAND
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] base_i,
    input  logic [N-1:0] mask_i,
    output logic         valid_o,
    output logic [W-1:0] idx_o,
    output logic         last_o,
    output logic         busy_o
);

    localparam logic [N-1:0] ONE = N'(1);

    seq_state_e   st_q, st_d;
    logic [N-1:0] rem_q, rem_d;
    logic [W-1:0] base_q, base_d;
    logic [W-1:0] pick_idx;
    logic         pick_single;

    cand_pick_low #(.N(N), .W(W)) u_pick (
        .mask_i   (rem_q),
        .idx_o    (pick_idx),
        .single_o (pick_single)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SEQ_IDLE;
            rem_q  <= '0;
            base_q <= '0;
        end else begin
            st_q   <= st_d;
            rem_q  <= rem_d;
            base_q <= base_d;
        end
    end

    // Next state
    always_comb begin
        st_d   = st_q;
        rem_d  = rem_q;
        base_d = base_q;
        unique case (st_q)
            SEQ_IDLE: begin
                if (start_i) begin
                    st_d   = SEQ_EMIT;
                    rem_d  = mask_i;
                    base_d = base_i;
                end
            end
            SEQ_EMIT: begin
                rem_d = rem_q & ~(ONE << pick_idx);
                if (pick_single) begin
                    st_d = SEQ_IDLE;
                end
            end
            default: st_d = SEQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        valid_o = 1'b0;
        last_o  = 1'b0;
        busy_o  = 1'b0;
        idx_o   = '0;
        unique case (st_q)
            SEQ_IDLE: ;
            SEQ_EMIT: begin
                valid_o = 1'b1;
                busy_o  = 1'b1;
                idx_o   = pick_idx;
                last_o  = pick_single;
            end
            default: ;
        endcase
    end

    // Checker state: entries emitted in the running sequence
    logic [W:0] emit_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            emit_cnt <= '0;
        end else if (st_q == SEQ_IDLE) begin
            emit_cnt <= '0;
        end else begin
            emit_cnt <= emit_cnt + 1'b1;
        end
    end

    assert_no_ac_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (!full_step(legs_of(base_q).a, legs_of(idx_o).a) &&
                     !full_step(legs_of(base_q).c, legs_of(idx_o).c)));

    assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o)) |-> (idx_o > $past(idx_o)));

    assert_idle_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !valid_o);

    assert_count_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (emit_cnt < (W+1)'(M)));

    assert_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (idx_o < W'(N)));

endmodule

// File: rtl/cand_seq_top.sv
module cand_seq_top
    import cand_seq_pkg::*;
#(
    parameter int N = NUM_STATES,
    parameter int W = IDX_W,
    parameter int M = MAX_CAND
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         apply,
    input  logic [W-1:0] apply_idx,
    output logic         cand_valid,
    output logic [W-1:0] cand_idx,
    output logic         cand_last,
    output logic         busy,
    output logic [W-1:0] applied_idx
);

    logic [W-1:0] applied_q;
    logic [N-1:0] perm_mask;
    logic         apply_ok;

    assign apply_ok = apply && (apply_idx < W'(N));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            applied_q <= '0;
        end else if (apply_ok) begin
            applied_q <= apply_idx;
        end
    end

    assign applied_idx = applied_q;

    cand_mask_gen #(.N(N), .W(W)) u_mask (
        .base_i (applied_q),
        .mask_o (perm_mask)
    );

    cand_seq_fsm #(.N(N), .W(W), .M(M)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .base_i  (applied_q),
        .mask_i  (perm_mask),
        .valid_o (cand_valid),
        .idx_o   (cand_idx),
        .last_o  (cand_last),
        .busy_o  (busy)
    );

    assert_hold_without_apply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(applied_idx));

    assert_range_guard_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && (apply_idx >= W'(N))) |=> $stable(applied_idx));

    assert_applied_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        applied_idx < W'(N));

endmodule

// File: tb/cand_seq_top_bench.sv
module cand_seq_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       apply = 1'b0;
    logic [4:0] apply_idx = '0;
    logic       cand_valid;
    logic [4:0] cand_idx;
    logic       cand_last;
    logic       busy;
    logic [4:0] applied_idx;

    int pass_cnt = 0;
    int fail_cnt = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cand_seq_top u_cand_seq_top (
        .clk(clk), .rst_n(rst_n), .start(start), .apply(apply), .apply_idx(apply_idx),
        .cand_valid(cand_valid), .cand_idx(cand_idx), .cand_last(cand_last),
        .busy(busy), .applied_idx(applied_idx)
    );

    // Leg levels written as decimal ABC digits
    int code [18] = '{0, 200, 220, 20, 22, 2, 202, 222, 120, 21, 102, 201, 100, 221, 121, 122, 1, 101};

    function automatic int leg(int idx, int which);
        int c = code[idx];
        if (which == 0) return c / 100;
        if (which == 1) return (c / 10) % 10;
        return c % 10;
    endfunction

    function automatic int absd(int x, int y);
        return (x > y) ? x - y : y - x;
    endfunction

    function automatic logic [17:0] exp_mask(int app);
        logic [17:0] m = '0;
        for (int c = 0; c < 18; c++) begin
            bit ok = (absd(leg(app, 0), leg(c, 0)) < 2) && (absd(leg(app, 2), leg(c, 2)) < 2);
            if (leg(app, 0) == 1 && leg(app, 2) == 1 && leg(app, 1) != leg(c, 1)) ok = 0;
            m[c] = ok;
        end
        return m;
    endfunction

    function automatic int pop(logic [17:0] m);
        int n = 0;
        for (int i = 0; i < 18; i++) n += m[i];
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        if (ok) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_apply(input int v);
        apply = 1'b1;
        apply_idx = 5'(v);
        @(negedge clk);
        apply = 1'b0;
    endtask

    // Runs one sequence; optional start pulse and apply at step k inside it.
    task automatic run_seq(input int restart_k, input int apply_k, input int apply_v,
                           output logic [17:0] got, output int n, output bit ordered,
                           output bit ended, output bit idle_after);
        int prev = -1;
        got = '0; n = 0; ordered = 1; ended = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 20 && !ended; k++) begin
            if (cand_valid) begin
                if (int'(cand_idx) <= prev) ordered = 0;
                prev = int'(cand_idx);
                if (cand_idx < 18) got[cand_idx] = 1'b1;
                n++;
                if (cand_last) ended = 1;
            end
            start = (k == restart_k);
            if (k == apply_k) begin apply = 1'b1; apply_idx = 5'(apply_v); end
            else apply = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        apply = 1'b0;
        idle_after = !cand_valid && !busy;
        @(negedge clk);
    endtask

    function automatic logic [17:0] lst(input int a [$]);
        logic [17:0] m = '0;
        foreach (a[i]) m[a[i]] = 1'b1;
        return m;
    endfunction

    initial begin
        #(5ns * 100000);
        if (!finished) begin
            fail_cnt++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
            $finish;
        end
    end

    initial begin
        logic [17:0] got;
        int n;
        bit ordered, ended, idle_after;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(applied_idx == 0, "R1 applied", applied_idx, 0);
        chk(!cand_valid && !cand_last && !busy, "R1 outputs", {cand_valid, cand_last, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(applied_idx == 0 && !busy, "R1 after release", applied_idx, 0);

        // Sweep every applied state (R3 R4 R5 R6 R7)
        for (int s = 0; s < 18; s++) begin
            do_apply(s);
            chk(applied_idx == 5'(s), "R2 load", applied_idx, s);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(cand_valid && busy, "R3 first candidate next cycle", {cand_valid, busy}, 3);
            @(negedge clk);
            while (busy) @(negedge clk);
            run_seq(99, 99, 0, got, n, ordered, ended, idle_after);
            chk(got == exp_mask(s), $sformatf("R5 R6 set from %0d", s), got, exp_mask(s));
            chk(ordered, "R4 ascending", ordered, 1);
            chk(ended && n == pop(exp_mask(s)), "R4 last marker", n, pop(exp_mask(s)));
            chk(idle_after, "R4 idle after last", idle_after, 1);
            chk(n <= 12 && got[s], "R7 size and self", n, 12);
        end

        // Listed sets (R5, R6)
        do_apply(12);
        run_seq(99, 99, 0, got, n, ordered, ended, idle_after);
        chk(got == lst('{0,1,2,3,8,9,11,12,13,14,16,17}), "R5 from 12", got, lst('{0,1,2,3,8,9,11,12,13,14,16,17}));
        do_apply(14);
        run_seq(99, 99, 0, got, n, ordered, ended, idle_after);
        chk(got == lst('{2,3,4,7,8,9,13,14,15}), "R6 from 14", got, lst('{2,3,4,7,8,9,13,14,15}));
        do_apply(17);
        run_seq(99, 99, 0, got, n, ordered, ended, idle_after);
        chk(got == lst('{0,1,5,6,10,11,12,16,17}), "R6 from 17", got, lst('{0,1,5,6,10,11,12,16,17}));
        do_apply(7);
        run_seq(99, 99, 0, got, n, ordered, ended, idle_after);
        chk(got == lst('{6,7,10,11,13,14,15,17}), "R5 from 7", got, lst('{6,7,10,11,13,14,15,17}));
        do_apply(0);
        run_seq(99, 99, 0, got, n, ordered, ended, idle_after);
        chk(got == lst('{0,3,8,9,12,14,16,17}), "R5 from 0", got, lst('{0,3,8,9,12,14,16,17}));

        // R8 start while busy ignored
        do_apply(12);
        run_seq(2, 99, 0, got, n, ordered, ended, idle_after);
        chk(n == 12 && got == exp_mask(12), "R8 restart ignored", n, 12);
        chk(idle_after, "R8 no extra sequence", idle_after, 1);
        run_seq(10, 99, 0, got, n, ordered, ended, idle_after);
        chk(n == 12 && idle_after, "R8 start on late entry", n, 12);

        // R9 apply during a sequence
        do_apply(12);
        run_seq(99, 3, 14, got, n, ordered, ended, idle_after);
        chk(got == exp_mask(12), "R9 running set kept", got, exp_mask(12));
        chk(applied_idx == 14, "R9 apply taken", applied_idx, 14);
        run_seq(99, 99, 0, got, n, ordered, ended, idle_after);
        chk(got == exp_mask(14), "R9 next set uses new", got, exp_mask(14));

        // R2 out-of-range apply and hold
        do_apply(20);
        chk(applied_idx == 14, "R2 idx 20 ignored", applied_idx, 14);
        do_apply(31);
        chk(applied_idx == 14, "R2 idx 31 ignored", applied_idx, 14);
        apply_idx = 5'd3;
        repeat (3) @(negedge clk);
        chk(applied_idx == 14, "R2 hold without strobe", applied_idx, 14);

        finished = 1;
        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    end

endmodule